// File: doc/BRIEF.md
# Vector Carry-Less Byte Multiplier

This unit multiplies pairs of bytes as polynomials over GF(2) and returns 16-bit products, eight lanes at a time. Two 128-bit source vectors come in together with an encoding (a two-bit size field and a U bit) and two lane-sourcing controls. The products are written into a 128-bit result vector that is registered once, so the result appears one clock after the request.

Lanes can be sourced in two ways. In half mode, the half-select bit chooses the lower or upper 64 bits of both sources, and the eight bytes of that half become the eight lanes. In pair mode, every 16-bit element of each source gives up either its low or its high byte, as the same select bit decides, and the product takes that element's place in the result.

The encoding is decoded into three classes: legal, undefined and unsupported. The decoder is an enumerated classifier with three states: `DEC_LEGAL`, `DEC_UNDEF` and `DEC_UNSUP`. It moves from any input to `DEC_UNDEF` when U is set, or when U is clear and size is 1 or 2. It moves to `DEC_UNSUP` when U is clear and size is 3. It moves to `DEC_LEGAL` when U is clear and size is 0. Only the legal class lets the products through.

Top module: `vpm_pmull_unit`

## Requirements
- R1: Each lane's 16-bit product is the carry-less product of two bytes: for each bit i set in the first byte, the second byte shifted left by i is XORed into the result (for example FF x FF = 5555 and 80 x 80 = 4000, in hex).
- R2: With `lane_mode` = 0, byte k (k = 0..7) of bits [63:0] of each source when `sel_hi` = 0, or of bits [127:64] when `sel_hi` = 1, feeds lane k, and that lane's product appears at result bits [16k+15:16k].
- R3: With `lane_mode` = 1, 16-bit element k of each source supplies its bits [7:0] when `sel_hi` = 0 or its bits [15:8] when `sel_hi` = 1, and that lane's product appears at result bits [16k+15:16k].
- R4: A request with `u_bit` = 1 sets `undef_flag` and clears `unsup_flag`, whatever the size.
- R5: A request with `u_bit` = 0 and size 1 or 2 sets `undef_flag` and clears `unsup_flag`.
- R6: A request with `u_bit` = 0 and size 3 sets `unsup_flag` and clears `undef_flag`. Size 0 with `u_bit` = 0 clears both flags.
- R7: When either flag is set, the result is all zeros.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and the result and flags for that request are available in that same cycle.
- R9: While `rst_n` is low at a clock edge, `out_valid`, the result and both flags are cleared, even if `in_valid` is high.
- R10: A cycle with `in_valid` low leaves the result and flags unchanged and drives `out_valid` low.
- R11: A zero byte in either operand gives a zero product in that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| size | input | 2 | Element size field of the encoding |
| u_bit | input | 1 | U bit of the encoding |
| sel_hi | input | 1 | Picks the upper half or the high byte |
| lane_mode | input | 1 | 0: half mode, 1: pair mode |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | Eight 16-bit products |
| undef_flag | output | 1 | Encoding is undefined |
| unsup_flag | output | 1 | Encoding names the 64-bit form, which is not computed here |

## Verification
The encoding decode and the product datapath act in the same cycle, and the decode must win. To provoke this, the bench sends all-ones operands, whose products would be 5555 in every lane, with every undefined and unsupported encoding. It then judges the registered result to be zero and checks that only the matching flag is raised. In a second case, reset and a valid request land on the same edge. The bench holds `in_valid` high while `rst_n` is low and expects the cleared state.

// File: rtl/vpm_pkg.sv
`timescale 1ns/1ps
package vpm_pkg;
    typedef enum logic [1:0] {
        DEC_LEGAL = 2'd0,
        DEC_UNDEF = 2'd1,
        DEC_UNSUP = 2'd2
    } dec_class_e;

    typedef enum logic {
        PICK_HALF = 1'b0,
        PICK_PAIR = 1'b1
    } pick_mode_e;
endpackage

// File: rtl/vpm_decode.sv
`timescale 1ns/1ps
module vpm_decode
    import vpm_pkg::*;
(
    input  logic [1:0]  size,
    input  logic        u_bit,
    output dec_class_e  cls
);
    always_comb begin
        if (u_bit) begin
            cls = DEC_UNDEF;
        end else begin
            unique case (size)
                2'd0:       cls = DEC_LEGAL;
                2'd1, 2'd2: cls = DEC_UNDEF;
                2'd3:       cls = DEC_UNSUP;
                default:    cls = DEC_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/vpm_lane_pick.sv
`timescale 1ns/1ps
module vpm_lane_pick
    import vpm_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    localparam int HALF_W = LANE_W * LANES,
    localparam int VEC_W  = 2 * HALF_W
) (
    input  logic [VEC_W-1:0]              src,
    input  pick_mode_e                    mode,
    input  logic                          sel_hi,
    output logic [LANES-1:0][LANE_W-1:0]  ops
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] half_lo, half_hi, pair_lo, pair_hi;
        assign half_lo = src[k*LANE_W +: LANE_W];
        assign half_hi = src[HALF_W + k*LANE_W +: LANE_W];
        assign pair_lo = src[2*k*LANE_W +: LANE_W];
        assign pair_hi = src[(2*k+1)*LANE_W +: LANE_W];
        always_comb begin
            unique case (mode)
                PICK_HALF: ops[k] = sel_hi ? half_hi : half_lo;
                PICK_PAIR: ops[k] = sel_hi ? pair_hi : pair_lo;
                default:   ops[k] = '0;
            endcase
        end
    end
endmodule

// File: rtl/vpm_clmul.sv
`timescale 1ns/1ps
module vpm_clmul #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [PW-1:0] p
);
    always_comb begin
        logic [PW-1:0] acc;
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (a[i]) acc = acc ^ ({{W{1'b0}}, b} << i);
        end
        p = acc;
    end
endmodule

// File: rtl/vpm_pmull_unit.sv
`timescale 1ns/1ps
module vpm_pmull_unit
    import vpm_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    localparam int PROD_W = 2 * LANE_W,
    localparam int VEC_W  = 2 * LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [1:0]        size,
    input  logic              u_bit,
    input  logic              sel_hi,
    input  logic              lane_mode,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result,
    output logic              undef_flag,
    output logic              unsup_flag
);
    dec_class_e                   cls;
    pick_mode_e                   mode;
    logic [LANES-1:0][LANE_W-1:0] ops_a, ops_b;
    logic [VEC_W-1:0]             prod;
    logic [VEC_W-1:0]             res_d;
    logic                         undef_d, unsup_d;

    assign mode = pick_mode_e'(lane_mode);

    vpm_decode u_dec (.size(size), .u_bit(u_bit), .cls(cls));

    vpm_lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick_a (
        .src(src_a), .mode(mode), .sel_hi(sel_hi), .ops(ops_a));
    vpm_lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick_b (
        .src(src_b), .mode(mode), .sel_hi(sel_hi), .ops(ops_b));

    for (genvar k = 0; k < LANES; k++) begin : g_mul
        vpm_clmul #(.W(LANE_W)) u_mul (
            .a(ops_a[k]), .b(ops_b[k]), .p(prod[k*PROD_W +: PROD_W]));
    end

    always_comb begin
        unique case (cls)
            DEC_LEGAL: begin res_d = prod; undef_d = 1'b0; unsup_d = 1'b0; end
            DEC_UNDEF: begin res_d = '0;   undef_d = 1'b1; unsup_d = 1'b0; end
            DEC_UNSUP: begin res_d = '0;   undef_d = 1'b0; unsup_d = 1'b1; end
            default:   begin res_d = '0;   undef_d = 1'b1; unsup_d = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            undef_flag <= 1'b0;
            unsup_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= res_d;
                undef_flag <= undef_d;
                unsup_flag <= unsup_d;
            end
        end
    end
endmodule

// File: rtl/vpm_check.sv
`timescale 1ns/1ps
module vpm_check #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] src_a,
    input logic [1:0]       size,
    input logic             u_bit,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             undef_flag,
    input logic             unsup_flag
);
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_flag, unsup_flag}));
    assert_u_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && u_bit |=> undef_flag && !unsup_flag);
    assert_mid_size_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !u_bit && (size == 2'd1 || size == 2'd2) |=> undef_flag);
    assert_wide_unsup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !u_bit && size == 2'd3 |=> unsup_flag && !undef_flag);
    assert_flag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_flag || unsup_flag) |-> result == '0);
    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result));
    assert_zero_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && src_a == '0 |=> result == '0);
endmodule

bind vpm_pmull_unit vpm_check #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
    .size(size), .u_bit(u_bit), .out_valid(out_valid), .result(result),
    .undef_flag(undef_flag), .unsup_flag(unsup_flag));

// File: tb/sim_vpm_pmull_unit.sv
`timescale 1ns/1ps
module sim_vpm_pmull_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0;
    logic [1:0]   size = 2'd0;
    logic         u_bit = 1'b0, sel_hi = 1'b0, lane_mode = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         undef_flag, unsup_flag;
    int           nchk = 0, nerr = 0;

    always #4 clk = ~clk;

    vpm_pmull_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .size(size), .u_bit(u_bit), .sel_hi(sel_hi), .lane_mode(lane_mode),
        .out_valid(out_valid), .result(result),
        .undef_flag(undef_flag), .unsup_flag(unsup_flag));

    function automatic logic [15:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] r = '0;
        logic [15:0] sh = {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            if (a[i]) r ^= sh;
            sh = sh << 1;
        end
        return r;
    endfunction

    // Place eight lane bytes into a source vector; other positions get filler.
    function automatic logic [127:0] place(logic [7:0][7:0] ops, logic md, logic hi,
                                           logic [127:0] fill);
        logic [127:0] v = fill;
        for (int k = 0; k < 8; k++) begin
            if (!md) v[(hi ? 64 : 0) + 8*k +: 8] = ops[k];
            else     v[16*k + (hi ? 8 : 0) +: 8] = ops[k];
        end
        return v;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [127:0] a, logic [127:0] b, logic [1:0] sz, logic u,
                         logic hi, logic md);
        @(negedge clk);
        src_a = a; src_b = b; size = sz; u_bit = u; sel_hi = hi; lane_mode = md;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_lanes(string req, logic [7:0][7:0] oa, logic [7:0][7:0] ob,
                             logic hi, logic md);
        logic [127:0] exp;
        for (int k = 0; k < 8; k++) exp[16*k +: 16] = ref_mul(oa[k], ob[k]);
        issue(place(oa, md, hi, {4{$urandom}}), place(ob, md, hi, {4{$urandom}}),
              2'd0, 1'b0, hi, md);
        chk(req, result, exp);
        chk({req, " flags/valid R8"}, {125'd0, out_valid, undef_flag, unsup_flag}, 128'b100);
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        logic [7:0][7:0] oa, ob;
        logic [127:0] held;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset state", {out_valid, undef_flag, unsup_flag, result}, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R1 directed corners, both modes and both selects (R2, R3)
        for (int c = 0; c < 4; c++) begin
            oa = {8'hFF, 8'h80, 8'h00, 8'h01, 8'hFF, 8'h80, 8'h53, 8'hCA};
            ob = {8'hFF, 8'h80, 8'hA5, 8'h00, 8'h01, 8'h02, 8'hCA, 8'h53};
            run_lanes((c[1] ? "R3 pair" : "R2 half"), oa, ob, c[0], c[1]);
        end
        // R11 zero operand in every lane
        run_lanes("R11 zero", '0, {8{8'hFF}}, 1'b1, 1'b0);

        // R4..R7: illegal encodings with all-ones operands
        for (int s = 0; s < 4; s++) begin
            for (int u = 0; u < 2; u++) begin
                logic [1:0] ef;
                if (u == 1)      ef = 2'b10;
                else if (s == 0) ef = 2'b00;
                else if (s == 3) ef = 2'b01;
                else             ef = 2'b10;
                issue({128{1'b1}}, {128{1'b1}}, s[1:0], u[0], 1'b0, 1'b0);
                chk(u == 1 ? "R4 flags" : (s == 3 ? "R6 flags" : "R5 flags"),
                    {126'd0, undef_flag, unsup_flag}, {126'd0, ef});
                chk("R7 result", result, (ef == 2'b00) ? {8{16'h5555}} : '0);
            end
        end

        // R10: inputs change with in_valid low, output holds
        run_lanes("R1 pre-hold", {8{8'h07}}, {8{8'h03}}, 1'b0, 1'b0);
        held = result;
        @(negedge clk);
        src_a = '1; src_b = '1; size = 2'd1; u_bit = 1'b1;
        @(negedge clk);
        chk("R10 hold", {out_valid, undef_flag, unsup_flag, result}, {3'b000, held});

        // R9: reset with a request on the same edge
        src_a = '1; src_b = '1; size = 2'd0; u_bit = 1'b0; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset wins", {out_valid, undef_flag, unsup_flag, result}, '0);
        in_valid = 1'b0; rst_n = 1'b1;

        // R1/R2/R3 exhaustive sweep over all byte pairs
        for (int a = 0; a < 256; a++) begin
            for (int g = 0; g < 32; g++) begin
                for (int k = 0; k < 8; k++) begin
                    oa[k] = a[7:0];
                    ob[k] = 8'(g * 8 + k);
                end
                run_lanes(((a ^ g) & 1) != 0 ? "R1 R3 sweep" : "R1 R2 sweep", oa, ob,
                          ((a >> 1) ^ g) & 1, (a ^ g) & 1);
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule